// File: doc/BRIEF.md
# Floor-free channel interleaver address generator

This block produces, one per clock, the permuted bit addresses of a two-step block interleaver. The permutation is laid out as 16 columns, and the number of rows is the block depth divided by 16. Three constellation modes are supported: QPSK, 16-QAM and 64-QAM. The block never divides or takes a general modulo. A stride accumulator supplies the column term. Two small wrapping counters supply the residues of the column and row indices, and a per-mode offset of at most two is added to the sum.

A bit-addressable block memory sits beside the generator, but it is not part of this block. A direction select decides where the permuted sequence goes. In interleave mode it drives the read port and the write port counts in natural order. In deinterleave mode the two ports swap. A start pulse latches the mode, the depth and the direction. The block then streams one address per cycle, with a valid flag, and raises a last flag on the final address.

The sequencer has two states. `SEQ_IDLE` waits for a start. The transition *launch* (start seen in `SEQ_IDLE`) moves it to `SEQ_RUN`. The transition *finish* (final column of the final row) returns it to `SEQ_IDLE`. Any start that arrives in `SEQ_RUN` is dropped.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low, and they stay low until a start pulse arrives.
- R2: A start pulse in idle makes `valid_o` high from the next cycle for exactly N consecutive cycles, where N is the latched depth. During those cycles the natural-order port carries 0, 1, ..., N-1.
- R3: Addresses are produced row-major, with the row index j running 0..r-1 on the outside and the column index i running 0..15 on the inside (r = N/16). When `mod_sel_i` is 0 (QPSK) or 3 (treated as QPSK), every address is r*i + j.
- R4: When `mod_sel_i` is 1 (16-QAM), even columns give r*i + j. Odd columns give r*i + j + 1 when j is even, and r*i + j - 1 when j is odd.
- R5: When `mod_sel_i` is 2 (64-QAM), columns with i mod 3 = 0 give r*i + j.
- R6: When `mod_sel_i` is 2, columns with i mod 3 = 1 give r*i + j + 2 if j mod 3 = 0, and r*i + j - 1 otherwise. Columns with i mod 3 = 2 give r*i + j - 2 if j mod 3 = 2, and r*i + j + 1 otherwise.
- R7: With `dir_i` = 0 the permuted address appears on `rd_addr_o` and the natural one on `wr_addr_o`. With `dir_i` = 1 the two are swapped.
- R8: `last_o` is high only together with `valid_o`, and only on the N-th address of the run.
- R9: Mode, depth and direction are captured only when a run is launched. Changing them during a run does not alter that run's addresses or its length.
- R10: A start pulse while a run is in progress is ignored. The run neither restarts nor lengthens.
- R11: The low four bits of `depth_i` are ignored, so N = `depth_i` rounded down to a multiple of 16. N must be at least 16. For 16-QAM r should be even, and for 64-QAM r should be a multiple of 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle launch request |
| mod_sel_i | input | 2 | Mode: 0 QPSK, 1 16-QAM, 2 64-QAM, 3 as QPSK |
| depth_i | input | 12 | Block depth in bits, a multiple of 16 |
| dir_i | input | 1 | 0 interleave (permuted read), 1 deinterleave (permuted write) |
| rd_addr_o | output | 12 | Memory read address |
| wr_addr_o | output | 12 | Memory write address |
| valid_o | output | 1 | Address pair valid this cycle |
| last_o | output | 1 | Final address of the block |

## Verification
The bench compares every address of each run against the textbook floor-and-modulo form of the two permutation steps. That comparison exposes a wrong residue counter, for example one that does not wrap at the row boundary, because such a counter shifts the ±1 and ±2 corrections into the wrong columns. It also catches an accumulator that is not cleared at each row, which makes the address drift upward. Runs use small row counts such as r = 3 and r = 4, where a row-end or run-end condition that is off by one becomes visible as a missing address, an extra address or a misplaced last flag. Mid-run changes to the configuration, together with a second start, catch a design that resamples its inputs or restarts. A depth with nonzero low bits catches a design that counts those bits into the run length.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        MOD_QPSK  = 2'd0,
        MOD_QAM16 = 2'd1,
        MOD_QAM64 = 2'd2,
        MOD_ALT   = 2'd3
    } ilv_mod_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } ilv_seq_e;

    localparam int unsigned ILV_COLS = 16;

endpackage

// File: rtl/ilv_offset.sv
module ilv_offset
    import ilv_pkg::*;
(
    input  ilv_mod_e          mod_i,
    input  logic              col_lsb_i,
    input  logic              row_lsb_i,
    input  logic [1:0]        col_m3_i,
    input  logic [1:0]        row_m3_i,
    output logic signed [2:0] off_o
);

    always_comb begin
        off_o = 3'sd0;
        unique case (mod_i)
            MOD_QAM16: begin
                if (col_lsb_i)
                    off_o = row_lsb_i ? -3'sd1 : 3'sd1;
            end
            MOD_QAM64: begin
                if (col_m3_i == 2'd1)
                    off_o = (row_m3_i == 2'd0) ? 3'sd2 : -3'sd1;
                else if (col_m3_i == 2'd2)
                    off_o = (row_m3_i == 2'd2) ? -3'sd2 : 3'sd1;
            end
            MOD_QPSK, MOD_ALT: off_o = 3'sd0;
        endcase
    end

endmodule

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
    import ilv_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mod_sel_i,
    input  logic [AW-1:0] depth_i,
    input  logic          dir_i,
    output logic          run_o,
    output logic          final_o,
    output logic [3:0]    col_o,
    output logic [AW-5:0] row_o,
    output logic [1:0]    col_m3_o,
    output logic [1:0]    row_m3_o,
    output logic [AW-1:0] stride_o,
    output logic [AW-1:0] nat_o,
    output ilv_mod_e      mod_o,
    output logic          dir_o
);

    localparam int unsigned CW = $clog2(ILV_COLS);
    localparam int unsigned RW = AW - CW;

    ilv_seq_e      state_q, state_nx;
    logic [RW-1:0] rows_q;
    logic          final_w;
    logic          unused_depth_lo;

    assign unused_depth_lo = ^depth_i[CW-1:0];
    assign final_w = (col_o == CW'(ILV_COLS - 1)) && (row_o == rows_q - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: launch and finish
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_i) state_nx = SEQ_RUN;
            SEQ_RUN:  if (final_w) state_nx = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run_o   = (state_q == SEQ_RUN);
        final_o = (state_q == SEQ_RUN) && final_w;
    end

    // index counters, residues and stride accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q   <= '0;
            col_o    <= '0;
            row_o    <= '0;
            col_m3_o <= '0;
            row_m3_o <= '0;
            stride_o <= '0;
            nat_o    <= '0;
            mod_o    <= MOD_QPSK;
            dir_o    <= 1'b0;
        end else if (state_q == SEQ_IDLE) begin
            if (start_i) begin
                rows_q   <= depth_i[AW-1:CW];
                mod_o    <= ilv_mod_e'(mod_sel_i);
                dir_o    <= dir_i;
                col_o    <= '0;
                row_o    <= '0;
                col_m3_o <= '0;
                row_m3_o <= '0;
                stride_o <= '0;
                nat_o    <= '0;
            end
        end else begin
            nat_o <= nat_o + 1'b1;
            if (col_o == CW'(ILV_COLS - 1)) begin
                col_o    <= '0;
                col_m3_o <= '0;
                stride_o <= '0;
                row_o    <= row_o + 1'b1;
                row_m3_o <= (row_m3_o == 2'd2) ? 2'd0 : row_m3_o + 2'd1;
            end else begin
                col_o    <= col_o + 1'b1;
                col_m3_o <= (col_m3_o == 2'd2) ? 2'd0 : col_m3_o + 2'd1;
                stride_o <= stride_o + {{CW{1'b0}}, rows_q};
            end
        end
    end

    assert_col_residue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (col_m3_o == 2'(col_o % 3)));

    assert_row_residue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (row_m3_o == 2'(row_o % 3)));

    assert_stride_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (stride_o == ({{CW{1'b0}}, rows_q} * {{RW{1'b0}}, col_o})));

    assert_config_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !final_o) |=> ($stable(mod_o) && $stable(dir_o) && $stable(rows_q)));

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
    import ilv_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mod_sel_i,
    input  logic [AW-1:0] depth_i,
    input  logic          dir_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          valid_o,
    output logic          last_o
);

    localparam int unsigned CW = $clog2(ILV_COLS);
    localparam int unsigned RW = AW - CW;

    logic              run_w, final_w, dir_w;
    logic [CW-1:0]     col_w;
    logic [RW-1:0]     row_w;
    logic [1:0]        col_m3_w, row_m3_w;
    logic [AW-1:0]     stride_w, nat_w, perm_w;
    logic signed [2:0] off_w;
    ilv_mod_e          mod_w;

    ilv_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mod_sel_i (mod_sel_i),
        .depth_i   (depth_i),
        .dir_i     (dir_i),
        .run_o     (run_w),
        .final_o   (final_w),
        .col_o     (col_w),
        .row_o     (row_w),
        .col_m3_o  (col_m3_w),
        .row_m3_o  (row_m3_w),
        .stride_o  (stride_w),
        .nat_o     (nat_w),
        .mod_o     (mod_w),
        .dir_o     (dir_w)
    );

    ilv_offset u_off (
        .mod_i     (mod_w),
        .col_lsb_i (col_w[0]),
        .row_lsb_i (row_w[0]),
        .col_m3_i  (col_m3_w),
        .row_m3_i  (row_m3_w),
        .off_o     (off_w)
    );

    assign perm_w    = stride_w + {{CW{1'b0}}, row_w} + {{(AW-3){off_w[2]}}, off_w};
    assign rd_addr_o = dir_w ? nat_w  : perm_w;
    assign wr_addr_o = dir_w ? perm_w : nat_w;
    assign valid_o   = run_w;
    assign last_o    = final_w;

    assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_run_ends_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o) |=> !valid_o);

    assert_run_not_broken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    assert_natural_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (nat_w == $past(nat_w) + 1'b1));

endmodule

// File: tb/ilv_addr_gen_tb.sv
`timescale 1ns/1ps
module ilv_addr_gen_tb_top;

    localparam int AW = 12;
    localparam int NCFG = 8;
    // fields: mode, depth, dir, perturb
    localparam int CFG [NCFG][4] = '{
        '{0,  48, 0, 0},
        '{1, 192, 0, 1},
        '{2, 288, 1, 0},
        '{1,  64, 1, 1},
        '{2, 144, 0, 1},
        '{3,  96, 1, 0},
        '{0, 100, 0, 0},
        '{2,  48, 1, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mod_sel_i = 2'd0;
    logic [AW-1:0] depth_i = '0;
    logic          dir_i = 1'b0;
    logic [AW-1:0] rd_addr_o, wr_addr_o;
    logic          valid_o, last_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilv_addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mod_sel_i(mod_sel_i),
        .depth_i(depth_i), .dir_i(dir_i), .rd_addr_o(rd_addr_o),
        .wr_addr_o(wr_addr_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // two-step permutation written with floor and modulo
    function automatic int ref_addr(int mode, int n, int nbits);
        int r, i, j, m, s;
        r = nbits / 16;
        i = n % 16;
        j = n / 16;
        m = r * i + j;
        s = (mode == 2) ? 3 : (mode == 1) ? 2 : 1;
        return s * (m / s) + ((m + nbits - (16 * m) / nbits) % s);
    endfunction

    function automatic string perm_tag(int mode, int n);
        if (mode == 1) return "R4 16-QAM address";
        if (mode == 2) return ((n % 16) % 3 == 0) ? "R5 64-QAM address" : "R6 64-QAM address";
        return "R3 QPSK address";
    endfunction

    task automatic run_cfg(int mode, int depth, int dir, int perturb);
        int nbits, err0, perm, nat;
        nbits = depth & ~15;
        err0  = errors;
        @(negedge clk);
        mod_sel_i = 2'(mode);
        depth_i   = AW'(depth);
        dir_i     = dir[0];
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < nbits; n++) begin
            perm = dir ? int'(wr_addr_o) : int'(rd_addr_o);
            nat  = dir ? int'(rd_addr_o) : int'(wr_addr_o);
            chk(perturb ? "R10 valid during run" : "R2 valid during run", int'(valid_o), 1);
            chk(perm_tag(mode, n), perm, ref_addr(mode, n, nbits));
            chk("R7 natural-order port", nat, n);
            chk("R8 last flag", int'(last_o), (n == nbits - 1) ? 1 : 0);
            if (perturb != 0 && n == 3) begin
                mod_sel_i = 2'(mode + 1);
                depth_i   = AW'(depth + 32);
                dir_i     = ~dir[0];
                start_i   = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk((depth % 16 != 0) ? "R11 run length ignores low depth bits" : "R2 valid drops after N",
            int'(valid_o), 0);
        chk("R8 last low after run", int'(last_o), 0);
        if (perturb != 0)
            chk("R9 run unaffected by mid-run config change", errors - err0, 0);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(valid_o), 0);
        chk("R1 last after reset", int'(last_o), 0);
        rst_n = 1'b1;
        // config changes without start must not launch
        @(negedge clk);
        depth_i = 12'd64; mod_sel_i = 2'd2; dir_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle without start", int'(valid_o), 0);

        for (int c = 0; c < NCFG; c++)
            run_cfg(CFG[c][0], CFG[c][1], CFG[c][2], CFG[c][3]);

        // back-to-back launch right after a run ends
        run_cfg(1, 32, 0, 0);
        run_cfg(2, 48, 0, 0);
        repeat (2) @(negedge clk);
        chk("R2 idle after final run", int'(valid_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule